// File: doc/BRIEF.md
# Dual-Bank DMA Channel Controller

This block controls a set of DMA channels split into two banks of equal size. Each bank holds seven channels by default. Every channel has a 16-byte register window with three registers: a memory address, a block-size word and a control word. Each bank also has an enable register and an interrupt-flag register. Software programs a channel and sets the go bit in its control word. The channel is armed only when its own enable bit in the bank's enable register is also set.

While a channel is running, it raises a request toward its device. On every acknowledge, the device reports how many bytes it has moved. The controller then advances the address and reduces the remaining byte count by that amount. When nothing is left, the hardware clears the go bit and latches a sticky flag for that channel. The bank's interrupt output stays high while any flag in the bank is set.

The register port is synchronous and 32 bits wide, with a 16-bit byte offset. Read data appears one cycle after the read strobe.

Top module: `dmac_dual_bank`

## Requirements
- R1: After reset, every register reads 0, all device requests are low and both interrupt outputs are low.
- R2: Channel windows are laid out as follows.
  - Channel c in bank 0 (c < 7) sits at 0x1080 + 16·c. Channel 7+k in bank 1 sits at 0x1500 + 16·k.
  - Within a window, the address register is at +0x0, the block-size register at +0x4 and the control register at +0xC.
  - Each bank's enable register is at bank base + 0x70, and its flag register is at bank base + 0x74.
  - Writes land only in the addressed register.
- R3: A channel starts only when control bit 24 is set and bit (3 + 4·k) of its bank's enable register is set, where k is the channel's index within the bank. With either bit missing, the channel raises no request.
- R4: The transfer length in bytes is 4 × block[31:16] × block[15:0]. The request stays high until that many bytes have been acknowledged.
- R5: At completion, the hardware clears control bit 24 and sets the channel's flag bit k in its bank's flag register. The bank interrupt (irq[0] for bank 0, irq[1] for bank 1) goes high.
- R6: On each accepted acknowledge, the address register increases by the reported byte count and the remaining length drops by the same amount. A count larger than the remaining length is clamped to the remaining length.
- R7: While a channel is running, software writes to its address, block-size and control registers are ignored.
- R8: In any cycle, at most one acknowledge is accepted: the one from the lowest-numbered requesting channel. Acknowledges from other channels in that cycle have no effect.
- R9: Flag bits are cleared by writing 1 to them. Writing 0 leaves a flag unchanged. A bank's interrupt falls once all of its flags are clear.
- R10: A started channel whose computed length is zero completes one cycle after it starts. It never raises its device request.
- R11: Control bit 0 sets the direction output of the channel: 1 means memory to device, 0 means device to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| dev_req | output | 14 | Per-channel transfer request |
| dev_dir | output | 14 | Per-channel direction (1 = memory to device) |
| dev_ack | input | 14 | Per-channel chunk acknowledge |
| dev_cnt | input | 224 | Per-channel byte count for each acknowledge, 16 bits each, channel 0 in the low bits |
| irq | output | 2 | Per-bank interrupt |

## Verification
A stale or corrupted remaining-length counter shows up at the ports in one of two ways. The request may drop before the programmed number of bytes has been acknowledged. Or the go bit and flag may stay set after the final chunk. Both can be seen on the cycle after the last acknowledge. A broken priority pick shows up as the wrong channel's address advancing in the cycle after a double acknowledge, and a readback catches it. A start-qualification fault shows up as a request appearing one cycle after a write that should not have armed the channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 16;
  localparam int REM_W      = 34;
  localparam int GO_BIT     = 24;
  localparam int DIR_BIT    = 0;
  localparam logic [3:0] SUB_ADDR = 4'h0;
  localparam logic [3:0] SUB_BLK  = 4'h4;
  localparam logic [3:0] SUB_CTL  = 4'hC;
  localparam logic [15:0] EN_OFS   = 16'h0070;
  localparam logic [15:0] FLAG_OFS = 16'h0074;

  // total bytes = 4 * hi * lo
  function automatic logic [REM_W-1:0] block_bytes(input logic [REG_W-1:0] blk);
    logic [31:0] prod;
    prod = 32'(blk[31:16]) * 32'(blk[15:0]);
    return {prod, 2'b00};
  endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_addr,
  input  logic             wr_blk,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             go_en,
  input  logic             served,
  input  logic [CNT_W-1:0] step_in,
  output logic [REG_W-1:0] addr_q,
  output logic [REG_W-1:0] blk_q,
  output logic [REG_W-1:0] ctl_q,
  output logic             req,
  output logic             dir,
  output logic             done
);
  logic             running;
  logic [REM_W-1:0] remain;
  logic [CNT_W-1:0] step;
  logic             start_go;

  assign start_go = !running && ctl_q[GO_BIT] && go_en;
  assign done     = running && (remain == '0);
  assign req      = running && (remain != '0);
  assign dir      = ctl_q[DIR_BIT];

  always_comb begin
    if (remain < REM_W'(step_in)) step = remain[CNT_W-1:0];
    else                          step = step_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      blk_q   <= '0;
      ctl_q   <= '0;
      running <= 1'b0;
      remain  <= '0;
    end else begin
      if (wr_addr && !running)      addr_q <= wdata;
      else if (served && req)       addr_q <= addr_q + REG_W'(step);
      if (wr_blk && !running)       blk_q  <= wdata;
      if (wr_ctl && !running)       ctl_q  <= wdata;
      else if (done)                ctl_q[GO_BIT] <= 1'b0;
      if (start_go) begin
        running <= 1'b1;
        remain  <= block_bytes(blk_q);
      end else if (done) begin
        running <= 1'b0;
      end else if (served && req) begin
        remain  <= remain - REM_W'(step);
      end
    end
  end

  // R5
  go_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> !ctl_q[GO_BIT]);
  // R7
  addr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_addr && running && !served) |=> $stable(addr_q));
  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start_go && block_bytes(blk_q) == '0) |=> !req);
endmodule

// File: rtl/dmac_pick.sv
module dmac_pick #(
  parameter int NCH = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ack,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant
);
  logic [NCH-1:0] cand;
  assign cand  = ack & req;
  assign grant = cand & (~cand + NCH'(1));

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R8
  grant_src_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~ack) == '0);
endmodule

// File: rtl/dmac_bank.sv
module dmac_bank
  import dmac_pkg::*;
#(
  parameter int CPB = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic             flag_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [CPB-1:0]   done,
  output logic [REG_W-1:0] en_q,
  output logic [CPB-1:0]   flag_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      flag_q <= (flag_q & ~(flag_we ? wdata[CPB-1:0] : '0)) | done;
    end
  end

  assign irq = |flag_q;

  // R5
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|done) |=> irq);
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && done == '0) |=> ((flag_q & $past(wdata[CPB-1:0])) == '0));
endmodule

// File: rtl/dmac_dual_bank.sv
module dmac_dual_bank
  import dmac_pkg::*;
#(
  parameter int          CPB   = 7,
  parameter logic [15:0] BASE0 = 16'h1080,
  parameter logic [15:0] BASE1 = 16'h1500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [2*CPB-1:0]     dev_req,
  output logic [2*CPB-1:0]     dev_dir,
  input  logic [2*CPB-1:0]     dev_ack,
  input  logic [2*CPB*CNT_W-1:0] dev_cnt,
  output logic [1:0]           irq
);
  localparam int NB  = 2;
  localparam int NCH = NB * CPB;

  function automatic logic [15:0] bank_base(input int b);
    return (b == 0) ? BASE0 : BASE1;
  endfunction

  logic [REG_W-1:0] addr_r [NCH];
  logic [REG_W-1:0] blk_r  [NCH];
  logic [REG_W-1:0] ctl_r  [NCH];
  logic [NCH-1:0]   hit, done_v, grant;
  logic [REG_W-1:0] en_r   [NB];
  logic [CPB-1:0]   flag_r [NB];
  logic [NB-1:0]    en_hit, flag_hit;
  logic [REG_W-1:0] rd_mux;

  dmac_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst(rst), .ack(dev_ack), .req(dev_req), .grant(grant)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign en_hit[b]   = reg_addr == bank_base(b) + EN_OFS;
    assign flag_hit[b] = reg_addr == bank_base(b) + FLAG_OFS;
    dmac_bank #(.CPB(CPB)) u_bank (
      .clk(clk), .rst(rst),
      .en_we(reg_wr && en_hit[b]), .flag_we(reg_wr && flag_hit[b]),
      .wdata(reg_wdata), .done(done_v[b*CPB +: CPB]),
      .en_q(en_r[b]), .flag_q(flag_r[b]), .irq(irq[b])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam int BK = i / CPB;
    localparam int LC = i % CPB;
    localparam logic [15:0] WIN = bank_base(BK) + 16'(LC * 16);
    assign hit[i] = reg_addr[15:4] == WIN[15:4];
    dmac_chan u_chan (
      .clk(clk), .rst(rst),
      .wr_addr(reg_wr && hit[i] && reg_addr[3:0] == SUB_ADDR),
      .wr_blk (reg_wr && hit[i] && reg_addr[3:0] == SUB_BLK),
      .wr_ctl (reg_wr && hit[i] && reg_addr[3:0] == SUB_CTL),
      .wdata(reg_wdata),
      .go_en(en_r[BK][3 + 4*LC]),
      .served(grant[i]),
      .step_in(dev_cnt[i*CNT_W +: CNT_W]),
      .addr_q(addr_r[i]), .blk_q(blk_r[i]), .ctl_q(ctl_r[i]),
      .req(dev_req[i]), .dir(dev_dir[i]), .done(done_v[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) begin
        case (reg_addr[3:0])
          SUB_ADDR: rd_mux = addr_r[i];
          SUB_BLK:  rd_mux = blk_r[i];
          SUB_CTL:  rd_mux = ctl_r[i];
          default:  rd_mux = '0;
        endcase
      end
    end
    for (int b = 0; b < NB; b++) begin
      if (en_hit[b])   rd_mux = en_r[b];
      if (flag_hit[b]) rd_mux = REG_W'(flag_r[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: tb/sim_dmac_dual_bank.sv
module sim_dmac_dual_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 14;

  logic clk = 0, rst = 1;
  logic [15:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] dev_req, dev_dir, dev_ack = '0;
  logic [NCH*16-1:0] dev_cnt = '0;
  logic [1:0] irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_dual_bank u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .dev_req(dev_req), .dev_dir(dev_dir), .dev_ack(dev_ack),
    .dev_cnt(dev_cnt), .irq(irq)
  );

  int errors = 0, checks = 0;
  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];
  logic rd_pend = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values
  always @(posedge clk) rd_pend <= reg_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      if (sb.size() == 0) check("scoreboard empty", 32'h1, 32'h0);
      else begin
        e = sb.pop_front();
        check(e.tag, reg_rdata, e.val);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic ack2(input int c0, input int c1, input logic [15:0] n);
    @(negedge clk);
    dev_ack = '0;
    dev_ack[c0] = 1'b1; dev_cnt[c0*16 +: 16] = n;
    if (c1 >= 0) begin dev_ack[c1] = 1'b1; dev_cnt[c1*16 +: 16] = n; end
    @(negedge clk);
    dev_ack = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    check("R1 dev_req", 32'(dev_req), 0);
    check("R1 irq", 32'(irq), 0);
    rd(16'h108C, 32'h0, "R1 ch0 ctl");
    rd(16'h10F4, 32'h0, "R1 bank0 flags");
    rd(16'h1574, 32'h0, "R1 bank1 flags");

    // R2 decode
    wr(16'h10B0, 32'hA000_0100);
    wr(16'h1520, 32'h0000_BEEF);
    rd(16'h10B0, 32'hA000_0100, "R2 ch3 addr");
    rd(16'h1520, 32'h0000_BEEF, "R2 ch9 addr");
    rd(16'h1524, 32'h0, "R2 ch9 blk untouched");
    rd(16'h10A0, 32'h0, "R2 ch2 addr untouched");

    // R3 gating, R11 direction
    wr(16'h1090, 32'h0000_1000);
    wr(16'h1094, 32'h0002_0003);
    wr(16'h109C, 32'h0100_0001);
    idle(3);
    check("R3 no req without enable", 32'(dev_req[1]), 0);
    check("R11 dir ch1", 32'(dev_dir[1]), 1);
    rd(16'h109C, 32'h0100_0001, "R3 go bit pending");
    wr(16'h10F0, 32'h0000_0080);
    idle(1);
    check("R3 req after enable", 32'(dev_req[1]), 1);

    // R7 locked while running
    wr(16'h1090, 32'h0000_5555);
    wr(16'h1094, 32'h0000_0001);
    rd(16'h1090, 32'h0000_1000, "R7 addr ignored");
    rd(16'h1094, 32'h0002_0003, "R7 blk ignored");

    // R6 progress, R4 length
    ack2(1, -1, 16'd8);
    rd(16'h1090, 32'h0000_1008, "R6 addr after 8");
    ack2(1, -1, 16'd8);
    rd(16'h1090, 32'h0000_1010, "R6 addr after 16");
    check("R4 req still up at 16 of 24", 32'(dev_req[1]), 1);
    ack2(1, -1, 16'd20);
    rd(16'h1090, 32'h0000_1018, "R6 clamped step");
    idle(1);
    check("R4 req down at 24", 32'(dev_req[1]), 0);
    rd(16'h109C, 32'h0000_0001, "R5 go bit cleared");
    rd(16'h10F4, 32'h0000_0002, "R5 flag bit1");
    check("R5 irq0", 32'(irq), 32'h1);

    // R9 W1C
    wr(16'h10F4, 32'h0000_0001);
    rd(16'h10F4, 32'h0000_0002, "R9 write of other bit keeps flag");
    check("R9 irq held", 32'(irq[0]), 1);
    wr(16'h10F4, 32'h0000_0002);
    rd(16'h10F4, 32'h0, "R9 flag cleared");
    check("R9 irq low", 32'(irq[0]), 0);

    // R8 priority: ch2 and ch8
    wr(16'h10A0, 32'h0000_2000);
    wr(16'h10A4, 32'h0001_0004);
    wr(16'h10AC, 32'h0100_0000);
    wr(16'h1510, 32'h0000_3000);
    wr(16'h1514, 32'h0001_0004);
    wr(16'h151C, 32'h0100_0000);
    wr(16'h10F0, 32'h0000_0880);
    wr(16'h1570, 32'h0000_0080);
    idle(1);
    check("R8 both req", 32'({dev_req[8], dev_req[2]}), 32'h3);
    check("R11 dir ch2", 32'(dev_dir[2]), 0);
    ack2(2, 8, 16'd4);
    rd(16'h10A0, 32'h0000_2004, "R8 ch2 won");
    rd(16'h1510, 32'h0000_3000, "R8 ch8 ignored");
    ack2(8, -1, 16'd4);
    rd(16'h1510, 32'h0000_3004, "R8 ch8 alone");

    // R10 zero length on ch10 (bank1 local3)
    wr(16'h1534, 32'h0000_0005);
    wr(16'h1570, 32'h0000_8080);
    wr(16'h153C, 32'h0100_0000);
    for (int k = 0; k < 4; k++) begin
      check("R10 no req", 32'(dev_req[10]), 0);
      idle(1);
    end
    rd(16'h153C, 32'h0, "R10 go bit cleared");
    rd(16'h1574, 32'h0000_0008, "R10 flag bit3");
    check("R10 irq1", 32'(irq[1]), 1);

    idle(2);
    check("scoreboard drained", 32'(sb.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule